// File: doc/BRIEF.md
# Register-Controlled Backlight PWM Generator

This block sits on the panel side of a display link and turns a handful of byte-wide control registers into one backlight PWM waveform. A host programs it over a simple register bus (3-bit address, write data, write strobe, combinational read data). The block counts a fixed base clock. The PWM period is an 8-bit pre-divider multiplied by a power of two, 2^N, where the exponent N is the programmed bit count. The duty resolution is that same power of two.

The brightness level is one byte or two bytes, chosen by the `WIDE_LEVEL` parameter. A 2-bit source-select field decides whether the register level drives the duty or whether an external PWM input passes straight through. A master enable forces the output low. The period length, the exponent, the level, the source select and the frequency-enable bit are copied into active registers only when a PWM period ends, so a period is never cut short. The enable bit acts at once.

Top module: `bl_pwm_ctrl`

## Requirements
- R1: After reset, the registers read: address 0 = 0x00, address 1 = 0x00, address 2 = `PN_MIN`, address 3 = 0x01, addresses 4 and 5 = 0x00, address 6 = `PN_MIN`, address 7 = `PN_MAX`.
- R2: Register map:
  - Address 0 bit 0 is the enable.
  - Address 1 holds the source select in bits 1:0 and the frequency-enable in bit 2.
  - Address 2 is the exponent in bits 4:0.
  - Address 3 is the pre-divider.
  - Address 4 is the level high byte and address 5 is the level low byte.
  - Addresses 6 and 7 are read-only limit registers; writes to them change nothing.
  - Unused bits read 0.
- R3: A pre-divider write of 0 is stored and read back as 1.
- R4: An exponent write uses only bits 4:0 and is clamped into [`PN_MIN`, `PN_MAX`]. The clamped value reads back.
- R5: With source select 2'b10 and the frequency-enable set, the PWM period is F × 2^N base-clock cycles.
- R6: With the frequency-enable clear, the period is `DEF_DIV` × 2^N cycles, whatever F holds.
- R7: In register mode, each period has F × L high cycles for 0 < L < 2^N − 1. A level L ≥ 2^N − 1 keeps the output high. L = 0 keeps it low.
- R8: With `WIDE_LEVEL` = 1 the level is high byte × 256 + low byte. With `WIDE_LEVEL` = 0 the level is the high byte alone, and the low byte has no effect on the output.
- R9: With source select 2'b00, 2'b01 or 2'b11 and the enable set, `pwm_out` equals `ext_pwm_in`.
- R10: With the enable clear, `pwm_out` is 0 in every mode, starting the cycle after the write.
- R11: New pre-divider, exponent, level, source-select and frequency-enable values take effect only at the end of the current period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wen | input | 1 | Write strobe, captured on the rising edge |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| ext_pwm_in | input | 1 | External PWM used in non-register modes |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
Read data is combinational, so a write shows on `bus_rdata` at the sample after its capturing edge. The enable also acts on `pwm_out` at that sample. Every other setting lands only at a period boundary. After a configuration change, the bench therefore waits two of the longest periods that any mix of old and new values could produce, then counts high cycles over exactly one new period. Because the waveform is periodic, that count does not depend on phase. The boundary rule itself is checked at a fixed offset of ten cycles after an observed rising edge, where the output must still show the old level.

// File: rtl/bl_pwm_ctrl.sv
module bl_pwm_ctrl #(
  parameter int unsigned PN_MIN     = 2,
  parameter int unsigned PN_MAX     = 10,
  parameter int unsigned DEF_DIV    = 3,
  parameter bit          WIDE_LEVEL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wen,
  output logic [7:0] bus_rdata,
  input  logic       ext_pwm_in,
  output logic       pwm_out
);

  localparam int unsigned STEP_W = PN_MAX;
  localparam logic [4:0] PMIN = 5'(PN_MIN);
  localparam logic [4:0] PMAX = 5'(PN_MAX);
  localparam logic [7:0] DDIV = 8'(DEF_DIV);
  localparam logic [1:0] SRC_REG = 2'b10;

  logic       bl_en, fen_reg;
  logic [1:0] src_reg;
  logic [4:0] pn_reg;
  logic [7:0] f_reg, lvl_hi, lvl_lo;

  logic       act_fen;
  logic [1:0] act_src;
  logic [4:0] act_pn;
  logic [7:0] act_f;
  logic [15:0] act_lvl;

  logic [7:0]        presc;
  logic [STEP_W-1:0] step;

  wire [15:0] lvl_next = WIDE_LEVEL ? {lvl_hi, lvl_lo} : {8'h00, lvl_hi};
  wire [4:0]  pn_wr    = (bus_wdata[4:0] < PMIN) ? PMIN :
                         (bus_wdata[4:0] > PMAX) ? PMAX : bus_wdata[4:0];
  wire [7:0]  f_eff    = act_fen ? act_f : DDIV;
  wire [16:0] max_step = (17'd1 << act_pn) - 17'd1;
  wire        presc_end  = (presc == f_eff - 8'd1);
  wire        period_end = presc_end && (17'(step) == max_step);
  wire        duty_on    = (act_lvl != 16'd0) &&
                           ((17'(act_lvl) >= max_step) || (16'(step) < act_lvl));

  assign pwm_out = bl_en & ((act_src == SRC_REG) ? duty_on : ext_pwm_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bl_en   <= 1'b0;
      src_reg <= 2'b00;
      fen_reg <= 1'b0;
      pn_reg  <= PMIN;
      f_reg   <= 8'd1;
      lvl_hi  <= 8'd0;
      lvl_lo  <= 8'd0;
    end else if (bus_wen) begin
      case (bus_addr)
        3'd0: bl_en <= bus_wdata[0];
        3'd1: begin
          src_reg <= bus_wdata[1:0];
          fen_reg <= bus_wdata[2];
        end
        3'd2: pn_reg <= pn_wr;
        3'd3: f_reg  <= (bus_wdata == 8'd0) ? 8'd1 : bus_wdata;
        3'd4: lvl_hi <= bus_wdata;
        3'd5: lvl_lo <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc   <= 8'd0;
      step    <= '0;
      act_fen <= 1'b0;
      act_src <= 2'b00;
      act_pn  <= PMIN;
      act_f   <= 8'd1;
      act_lvl <= 16'd0;
    end else if (period_end) begin
      presc   <= 8'd0;
      step    <= '0;
      act_fen <= fen_reg;
      act_src <= src_reg;
      act_pn  <= pn_reg;
      act_f   <= f_reg;
      act_lvl <= lvl_next;
    end else if (presc_end) begin
      presc <= 8'd0;
      step  <= step + 1'b1;
    end else begin
      presc <= presc + 8'd1;
    end
  end

  always_comb begin
    case (bus_addr)
      3'd0: bus_rdata = {7'd0, bl_en};
      3'd1: bus_rdata = {5'd0, fen_reg, src_reg};
      3'd2: bus_rdata = {3'd0, pn_reg};
      3'd3: bus_rdata = f_reg;
      3'd4: bus_rdata = lvl_hi;
      3'd5: bus_rdata = lvl_lo;
      3'd6: bus_rdata = {3'd0, PMIN};
      default: bus_rdata = {3'd0, PMAX};
    endcase
  end

  p_pn_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pn_reg >= PMIN) && (pn_reg <= PMAX));

  p_div_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    f_reg != 8'd0);

  p_dark_when_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bl_en |-> !pwm_out);

  p_latch_on_boundary_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_lvl != $past(act_lvl) || act_pn != $past(act_pn) || act_f != $past(act_f)
     || act_src != $past(act_src) || act_fen != $past(act_fen)) |-> $past(period_end));

  p_step_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
    17'(step) <= max_step);

  p_zero_level_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_src == SRC_REG && act_lvl == 16'd0) |-> !pwm_out);

endmodule

// File: tb/test_bl_pwm_ctrl.sv
module test_bl_pwm_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wen = 1'b0;
  logic       ext_pwm_in = 1'b0;
  logic [7:0] rdata_w, rdata_n;
  logic       pwm_w, pwm_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int cur_div = 1;
  int cur_pn = 2;

  always #10 clk = ~clk;

  bl_pwm_ctrl i_bl_pwm_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wen(bus_wen), .bus_rdata(rdata_w), .ext_pwm_in(ext_pwm_in), .pwm_out(pwm_w));

  bl_pwm_ctrl #(.WIDE_LEVEL(1'b0)) i_narrow (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wen(bus_wen), .bus_rdata(rdata_n), .ext_pwm_in(ext_pwm_in), .pwm_out(pwm_n));

  function automatic int exp_high(int f, int pn, int lvl);
    if (lvl == 0) return 0;
    if (lvl >= (1 << pn) - 1) return f << pn;
    return f * lvl;
  endfunction

  function automatic int clamp_pn(int raw);
    int v = raw & 31;
    if (v < 2) return 2;
    if (v > 10) return 10;
    return v;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    bus_addr = a;
    #1 d = int'(rdata_w);
  endtask

  task automatic count_high(input int n, output int hw, output int hn);
    hw = 0; hn = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_w) hw++;
      if (pwm_n) hn++;
    end
  endtask

  task automatic meas_period(output int p);
    logic prev;
    int guard = 0;
    @(negedge clk); prev = pwm_w;
    while (!(pwm_w && !prev) && guard < 20000) begin
      prev = pwm_w; @(negedge clk); guard++;
    end
    p = 0;
    do begin
      prev = pwm_w; @(negedge clk); p++;
    end while (!(pwm_w && !prev) && p < 20000);
  endtask

  task automatic cfg(input int mode, input int f, input int pn, input int lvl);
    int fe, pe, mx;
    fe = ((mode >> 2) & 1) ? ((f == 0) ? 1 : f) : 3;
    pe = clamp_pn(pn);
    wr(3'd1, 8'(mode));
    wr(3'd3, 8'(f));
    wr(3'd2, 8'(pn));
    wr(3'd4, 8'(lvl >> 8));
    wr(3'd5, 8'(lvl & 255));
    mx = ((fe > cur_div) ? fe : cur_div) << ((pe > cur_pn) ? pe : cur_pn);
    mx = (mx > 3 * (1 << ((pe > cur_pn) ? pe : cur_pn))) ? mx : 3 * (1 << ((pe > cur_pn) ? pe : cur_pn));
    repeat (2 * mx + 4) @(negedge clk);
    cur_div = fe; cur_pn = pe;
  endtask

  initial begin
    int d, hw, hn, p;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 mode", d, 0);
    rd(3'd2, d); chk("R1 pn", d, 2);
    rd(3'd3, d); chk("R1 div", d, 1);
    rd(3'd4, d); chk("R1 hi", d, 0);
    rd(3'd5, d); chk("R1 lo", d, 0);
    rd(3'd6, d); chk("R1 capmin", d, 2);
    rd(3'd7, d); chk("R1 capmax", d, 10);

    // R2 map, read-only limits, unused bits
    wr(3'd6, 8'hFF); rd(3'd6, d); chk("R2 capmin ro", d, 2);
    wr(3'd7, 8'h00); rd(3'd7, d); chk("R2 capmax ro", d, 10);
    wr(3'd0, 8'hFE); rd(3'd0, d); chk("R2 ctrl bits", d, 0);
    wr(3'd1, 8'hFF); rd(3'd1, d); chk("R2 mode bits", d, 7);
    wr(3'd4, 8'hA5); rd(3'd4, d); chk("R2 hi", d, 8'hA5);
    wr(3'd5, 8'h3C); rd(3'd5, d); chk("R2 lo", d, 8'h3C);

    // R3 zero divider
    wr(3'd3, 8'd0); rd(3'd3, d); chk("R3 div zero", d, 1);
    wr(3'd3, 8'd200); rd(3'd3, d); chk("R3 div", d, 200);

    // R4 exponent clamp
    wr(3'd2, 8'd0); rd(3'd2, d); chk("R4 low clamp", d, 2);
    wr(3'd2, 8'd31); rd(3'd2, d); chk("R4 high clamp", d, 10);
    wr(3'd2, 8'h25); rd(3'd2, d); chk("R4 field bits", d, 5);

    wr(3'd2, 8'd2); wr(3'd1, 8'd0); wr(3'd3, 8'd1);
    repeat (3 * (255 << 10) / 255 + 20) @(negedge clk);
    cur_div = 3; cur_pn = 2;
    wr(3'd0, 8'd1);

    // R5 period with frequency-enable
    cfg(6, 4, 3, 3);
    meas_period(p); chk("R5 period", p, 32);
    count_high(32, hw, hn); chk("R7 duty", hw, 12);

    // R6 default divider
    cfg(2, 4, 3, 3);
    meas_period(p); chk("R6 default period", p, 24);

    // R7 extremes
    cfg(6, 2, 3, 0); count_high(16, hw, hn); chk("R7 zero", hw, 0);
    cfg(6, 2, 3, 7); count_high(16, hw, hn); chk("R7 full at max", hw, 16);
    cfg(6, 2, 3, 300); count_high(16, hw, hn); chk("R7 full above", hw, 16);

    // R8 level width
    cfg(6, 2, 4, 16'h03FF); count_high(32, hw, hn);
    chk("R8 wide", hw, 32); chk("R8 narrow", hn, 6);
    cfg(6, 2, 4, 5); count_high(32, hw, hn);
    chk("R8 wide lo", hw, 10); chk("R8 narrow lo ignored", hn, 0);

    // R9 external pass-through
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      cfg(4 | m, 2, 3, 4);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk); ext_pwm_in = k[0];
        #1 chk("R9 ext follow", int'(pwm_w), k & 1);
      end
    end
    ext_pwm_in = 1'b0;

    // R10 enable gating
    cfg(6, 2, 3, 300);
    @(negedge clk); chk("R10 on before", int'(pwm_w), 1);
    wr(3'd0, 8'd0); chk("R10 off next", int'(pwm_w), 0);
    count_high(16, hw, hn); chk("R10 off period", hw, 0);
    ext_pwm_in = 1'b1; cfg(4, 2, 3, 0);
    count_high(8, hw, hn); chk("R10 off ext", hw, 0);
    ext_pwm_in = 1'b0;
    wr(3'd0, 8'd1);

    // R11 boundary update
    cfg(6, 2, 4, 8);
    begin
      logic prev;
      @(negedge clk); prev = pwm_w;
      while (!(pwm_w && !prev)) begin prev = pwm_w; @(negedge clk); end
    end
    wr(3'd5, 8'd0);
    repeat (8) @(negedge clk);
    chk("R11 old level holds", int'(pwm_w), 1);
    repeat (70) @(negedge clk);
    count_high(32, hw, hn); chk("R11 new level", hw, 0);

    // random mix, R5 R7 R8
    for (int it = 0; it < 12; it++) begin
      int rf, rp, pe, fe, lvl;
      rf = $urandom_range(0, 6);
      rp = $urandom_range(0, 7);
      pe = clamp_pn(rp);
      fe = (rf == 0) ? 1 : rf;
      lvl = $urandom_range(0, (1 << pe) + 2);
      cfg(6, rf, rp, lvl);
      rd(3'd2, d); chk("R4 rand pn", d, pe);
      rd(3'd3, d); chk("R3 rand div", d, fe);
      count_high(fe << pe, hw, hn);
      chk("R7 rand wide", hw, exp_high(fe, pe, lvl));
      chk("R8 rand narrow", hn, exp_high(fe, pe, lvl >> 8));
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule